// File: doc/BRIEF.md
# Two-Output Level Interrupt Router

This block collects 32 level-sensitive interrupt request lines, synchronizes them to the local clock and masks them with a per-source enable mask. Each source that is both asserted and enabled is sent to one of two CPU interrupt outputs, as chosen by a per-source routing bit. Bit 31 of the enable mask also acts as the master switch: while it is clear, both outputs stay low and both pending views read zero.

Software reaches the block over a plain register bus with an address, a write strobe, write data and combinational read data. The enable mask is never written directly. Software sets bits by writing ones to a set register, and clears bits by writing ones to a clear register. For the first output, the block also drives the index of the lowest-numbered pending source together with a valid flag, so that a handler can pick its next source without scanning the status word.

Top module: `irq_router`

## Requirements
- R1: Each interrupt line passes through two flip-flops. A level that is present before clock edge k is visible in the raw view (address 0x30) from edge k+1 onward.
- R2: A write to address 0x34 sets each enable bit whose write-data bit is 1 and leaves every other enable bit unchanged.
- R3: A write to address 0x38 clears each enable bit whose write-data bit is 1 and leaves every other enable bit unchanged. Writing all ones also clears bit 31.
- R4: While enable bit 31 is 0, `cpu_irq0` and `cpu_irq1` are low and the pending views at 0x00 and 0x04 read zero.
- R5: While enable bit 31 is 1, the pending view at 0x00 equals raw AND enable AND NOT route, and the view at 0x04 equals raw AND enable AND route. A route bit of 0 selects output 0 and a route bit of 1 selects output 1. The route register is written and read at address 0x20.
- R6: `cpu_irq0` is high exactly when the 0x00 view is non-zero, and `cpu_irq1` is high exactly when the 0x04 view is non-zero.
- R7: Address 0x30 reads the synchronized lines, with no mask applied.
- R8: Reads at 0x34 and at 0x38 both return the current enable mask. Any address other than 0x00, 0x04, 0x20, 0x30, 0x34 and 0x38 reads zero. Writes to 0x00, 0x04, 0x30 or to an unmapped address change no state.
- R9: `first_valid` is high exactly when the 0x00 view is non-zero. While it is high, `first_idx` is the position of the lowest set bit of that view.
- R10: After reset, the enable mask (master bit included) and the route register are zero, the synchronizer stages are zero and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_lines | input | 32 | Level-sensitive interrupt requests |
| cpu_irq0 | output | 1 | First CPU interrupt output |
| cpu_irq1 | output | 1 | Second CPU interrupt output |
| first_idx | output | 5 | Lowest pending source on the first output |
| first_valid | output | 1 | `first_idx` is meaningful |

## Verification
The hardest case to reach is a cycle in which a mask or route write lands while synchronized lines are still moving through the two flops. In that cycle the outputs depend on the new mask combined with inputs that are one or two cycles old. Line 31 adds a further case, because it shares its enable bit with the master switch. The bench first runs directed sequences: enable, route, master off and on, writes to read-only and unmapped addresses, and a clear of all ones. It then runs a long pseudo-random phase that changes lines, mask writes and route writes in neighbouring cycles. A cycle-level model is compared against every output on every clock.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;
    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MASTER_BIT = DATA_W - 1;

    localparam logic [ADDR_W-1:0] A_PEND0  = 8'h00;
    localparam logic [ADDR_W-1:0] A_PEND1  = 8'h04;
    localparam logic [ADDR_W-1:0] A_ROUTE  = 8'h20;
    localparam logic [ADDR_W-1:0] A_RAW    = 8'h30;
    localparam logic [ADDR_W-1:0] A_EN_SET = 8'h34;
    localparam logic [ADDR_W-1:0] A_EN_CLR = 8'h38;

    typedef struct packed {
        logic [DATA_W-1:0] en;
        logic [DATA_W-1:0] route;
    } cfg_t;

    typedef struct packed {
        logic [DATA_W-1:0] s1;
        logic [DATA_W-1:0] s2;
    } sync_t;
endpackage

// File: rtl/irq_router_sync.sv
module irq_router_sync
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] lines_in,
    output logic [DATA_W-1:0] lines_sync
);
    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = lines_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lines_sync = sync_q.s2;

    AST_SYNC_SECOND_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (lines_sync == $past(sync_q.s1))) else $error("sync stage");  // R1
endmodule

// File: rtl/irq_router_cfg.sv
module irq_router_cfg
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] en_mask,
    output logic [DATA_W-1:0] route_mask
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_EN_SET: cfg_d.en    = cfg_q.en | wr_data;
                A_EN_CLR: cfg_d.en    = cfg_q.en & ~wr_data;
                A_ROUTE:  cfg_d.route = wr_data;
                default:  cfg_d       = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_mask    = cfg_q.en;
    assign route_mask = cfg_q.route;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_SET) |=> ((en_mask & $past(wr_data)) == $past(wr_data)))
        else $error("set");  // R2
    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_EN_CLR) |=> ((en_mask & $past(wr_data)) == '0))
        else $error("clear");  // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en) |=> ($stable(en_mask) && $stable(route_mask))) else $error("hold");  // R8
endmodule

// File: rtl/irq_router_first.sv
module irq_router_first
    import irq_router_pkg::*;
(
    input  logic [DATA_W-1:0] pend,
    output logic [IDX_W-1:0]  idx,
    output logic              valid
);
    always_comb begin
        idx = '0;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

    assign valid = |pend;
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [DATA_W-1:0] irq_lines,
    output logic              cpu_irq0,
    output logic              cpu_irq1,
    output logic [IDX_W-1:0]  first_idx,
    output logic              first_valid
);
    logic [DATA_W-1:0] raw;
    logic [DATA_W-1:0] en_mask;
    logic [DATA_W-1:0] route_mask;
    logic [DATA_W-1:0] pend0;
    logic [DATA_W-1:0] pend1;
    logic              master;

    irq_router_sync u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .lines_in   (irq_lines),
        .lines_sync (raw)
    );

    irq_router_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (bus_we),
        .wr_addr    (bus_addr),
        .wr_data    (bus_wdata),
        .en_mask    (en_mask),
        .route_mask (route_mask)
    );

    assign master = en_mask[MASTER_BIT];

    always_comb begin
        pend0 = '0;
        pend1 = '0;
        if (master) begin
            pend0 = raw & en_mask & ~route_mask;
            pend1 = raw & en_mask & route_mask;
        end
    end

    irq_router_first u_first (
        .pend  (pend0),
        .idx   (first_idx),
        .valid (first_valid)
    );

    assign cpu_irq0 = |pend0;
    assign cpu_irq1 = |pend1;

    always_comb begin
        unique case (bus_addr)
            A_PEND0:  bus_rdata = pend0;
            A_PEND1:  bus_rdata = pend1;
            A_ROUTE:  bus_rdata = route_mask;
            A_RAW:    bus_rdata = raw;
            A_EN_SET: bus_rdata = en_mask;
            A_EN_CLR: bus_rdata = en_mask;
            default:  bus_rdata = '0;
        endcase
    end

    AST_MASTER_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        !en_mask[MASTER_BIT] |-> (!cpu_irq0 && !cpu_irq1)) else $error("master");  // R4
    AST_ROUTE_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
        (pend0 & pend1) == '0) else $error("route");  // R5
    AST_VALID_TRACKS_IRQ0: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid == cpu_irq0) else $error("valid");  // R9
    AST_FIRST_IS_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        first_valid |-> (pend0[first_idx] &&
            ((pend0 & ((DATA_W'(1) << first_idx) - DATA_W'(1))) == '0)))
        else $error("lowest");  // R9
endmodule

// File: tb/irq_router_bench.sv
module irq_router_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] irq_lines = '0;
    logic        cpu_irq0, cpu_irq1, first_valid;
    logic [4:0]  first_idx;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // behavioural model state
    bit [31:0] m_st1, m_st2, m_en, m_rt;
    bit [31:0] lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    irq_router u_irq_router (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .cpu_irq0(cpu_irq0), .cpu_irq1(cpu_irq1),
        .first_idx(first_idx), .first_valid(first_valid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    function automatic bit [31:0] nextrand();
        lfsr ^= lfsr << 13;
        lfsr ^= lfsr >> 17;
        lfsr ^= lfsr << 5;
        return lfsr;
    endfunction

    task automatic check_all();
        bit [31:0] p0, p1, rd;
        int lo;
        p0 = '0; p1 = '0;
        if (m_en[31]) begin
            p0 = m_st2 & m_en & ~m_rt;   // R5
            p1 = m_st2 & m_en & m_rt;
        end
        case (bus_addr)
            8'h00: rd = p0;
            8'h04: rd = p1;
            8'h20: rd = m_rt;
            8'h30: rd = m_st2;
            8'h34, 8'h38: rd = m_en;
            default: rd = '0;
        endcase
        lo = 0;
        for (int i = 31; i >= 0; i--) if (p0[i]) lo = i;
        chk("R7/R8 rdata", bus_rdata, rd);
        chk("R6 cpu_irq0", {31'b0, cpu_irq0}, {31'b0, (p0 != 0)});
        chk("R6 cpu_irq1", {31'b0, cpu_irq1}, {31'b0, (p1 != 0)});
        chk("R9 first_valid", {31'b0, first_valid}, {31'b0, (p0 != 0)});
        if (p0 != 0) chk("R9 first_idx", {27'b0, first_idx}, lo);
        if (!m_en[31]) chk("R4 master off", {30'b0, cpu_irq1, cpu_irq0}, 32'h0);
    endtask

    // check current outputs at negedge, then drive inputs for the next edge
    task automatic step(input bit rv, input bit we, input bit [7:0] a,
                        input bit [31:0] d, input bit [31:0] lines);
        @(negedge clk);
        check_all();
        rst_n = rv; bus_we = we; bus_addr = a; bus_wdata = d; irq_lines = lines;
        if (rv) begin
            m_st2 = m_st1;       // R1
            m_st1 = lines;
            if (we) begin
                if (a == 8'h34) m_en = m_en | d;       // R2
                else if (a == 8'h38) m_en = m_en & ~d; // R3
                else if (a == 8'h20) m_rt = d;
            end
        end else begin
            m_st1 = '0; m_st2 = '0; m_en = '0; m_rt = '0;  // R10
        end
    endtask

    task automatic rd(input bit [7:0] a, input bit [31:0] lines);
        step(1'b1, 1'b0, a, 32'h0, lines);
    endtask

    initial begin
        #(2_000_000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        bit [7:0] addrs [8];
        addrs = '{8'h00, 8'h04, 8'h20, 8'h30, 8'h34, 8'h38, 8'h10, 8'hFC};
        // R10: reset state with lines active
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, addrs[i % 8], '0, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) rd(addrs[i], 32'h0);
        // R2: enable low byte plus master
        step(1'b1, 1'b1, 8'h34, 32'h8000_00FF, 32'h0);
        // R1, R7: raw pattern appears after two edges
        rd(8'h30, 32'h0000_03A4);
        rd(8'h30, 32'h0000_03A4);
        rd(8'h30, 32'h0000_03A4);
        rd(8'h00, 32'h0000_03A4);
        // R5: route bits 2 and 7 to output 1
        step(1'b1, 1'b1, 8'h20, 32'h0000_0084, 32'h0000_03A4);
        rd(8'h04, 32'h0000_03A4);
        rd(8'h00, 32'h0000_03A4);
        rd(8'h20, 32'h0000_03A4);
        // R4: master off, then back on
        step(1'b1, 1'b1, 8'h38, 32'h8000_0000, 32'h0000_03A4);
        rd(8'h00, 32'h0000_03A4);
        rd(8'h04, 32'h0000_03A4);
        step(1'b1, 1'b1, 8'h34, 32'h8000_0000, 32'h0000_03A4);
        rd(8'h38, 32'h0000_03A4);
        // R8: writes to read-only and unmapped addresses are ignored
        step(1'b1, 1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0000_03A4);
        step(1'b1, 1'b1, 8'h30, 32'hFFFF_FFFF, 32'h0000_03A4);
        step(1'b1, 1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0000_03A4);
        step(1'b1, 1'b1, 8'h04, 32'hFFFF_FFFF, 32'h0000_03A4);
        rd(8'h34, 32'h0000_03A4);
        rd(8'h20, 32'h0000_03A4);
        rd(8'h10, 32'h0000_03A4);
        // R3: partial clear, then clear everything including master
        step(1'b1, 1'b1, 8'h38, 32'h0000_0020, 32'h0000_03A4);
        rd(8'h00, 32'h0000_03A4);
        step(1'b1, 1'b1, 8'h38, 32'hFFFF_FFFF, 32'h0000_03A4);
        rd(8'h34, 32'h0000_03A4);
        rd(8'h00, 32'h0000_03A4);
        // R9: only source 31 pending with master on
        step(1'b1, 1'b1, 8'h20, 32'h0, 32'h8000_0000);
        step(1'b1, 1'b1, 8'h34, 32'h8000_0000, 32'h8000_0000);
        rd(8'h00, 32'h8000_0000);
        rd(8'h00, 32'h8000_0000);
        // pseudo-random mix
        for (int i = 0; i < 4000; i++) begin
            bit [31:0] r, d, ln;
            r = nextrand(); d = nextrand(); ln = nextrand() & nextrand();
            if (r[3:0] == 4'd0) step(1'b1, 1'b1, 8'h34, d, ln);
            else if (r[3:0] == 4'd1) step(1'b1, 1'b1, 8'h38, d & nextrand(), ln);
            else if (r[3:0] == 4'd2) step(1'b1, 1'b1, 8'h20, d, ln);
            else if (r[3:0] == 4'd3) step(1'b1, 1'b1, 8'h38, 32'h8000_0000, ln);
            else if (r[3:0] == 4'd4) step(1'b1, 1'b1, addrs[r[6:4]], d, ln);
            else step(1'b1, 1'b0, addrs[r[6:4]], d, ln);
        end
        rd(8'h00, 32'h0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule